// File: doc/BRIEF.md
# Drift-Compensated Nanosecond Time-of-Day Counter

This block keeps a 64-bit time of day counted in nanoseconds and clocked by a reference clock. On every enabled reference cycle a 32-bit fractional accumulator gains the value of a programmable addend. Each carry out of that accumulator moves the time forward by a programmed nanosecond period. Software trims the rate by changing the addend. It steps the time by loading a new 64-bit value. A bypass mode drops the fractional stage and advances the time on every cycle.

Access goes through a small 32-bit register port with one cycle of read latency. Because the time is 64 bits wide, it is read and written as two halves, always low half first. A low-half read freezes a copy of the high half, so the pair read back is coherent. A low-half write is held back, and the whole 64-bit value loads together on the high-half write. The live time and a one-cycle advance strobe are also driven on output pins for local consumers.

Top module: `tod_ns_counter`

## Requirements
- R1: After reset the time, control word, addend and accumulator are all zero and `tick` is low.
- R2: With the enable bit (control bit 2) set and bypass clear, each cycle the accumulator becomes (accumulator + addend) mod 2^32. In every cycle where that sum carries out of bit 31, the time grows by the 10-bit period held in control bits 25:16.
- R3: With the enable bit clear, the time and the accumulator hold their values and `tick` stays low.
- R4: With enable and the bypass bit (control bit 3) both set, the time grows by the period on every cycle and the accumulator holds.
- R5: While the soft-reset bit (control bit 5) is set, the time, the accumulator, the staged low half and the frozen high half are forced to zero. The control word and the addend keep their values.
- R6: A write to the time-low address (1) only stages the value. A write to the time-high address (2) loads {high, staged low} into the time in one cycle, and the load takes priority over any advance in that cycle.
- R7: A read of time-low (1) returns the low half and freezes the high half of the same cycle. A later read of time-high (2) returns that frozen value, not the live one.
- R8: Writing the addend (address 3) changes only the rate from then on. The accumulator carries its fraction across the change.
- R9: The accumulator is writable and readable at address 4, and a write replaces its value for that cycle.
- R10: The time wraps modulo 2^64.
- R11: Read data appears on `rdata` one cycle after `rd_en`. The control word is at address 0 and keeps only bits 25:16, 5, 3 and 2. Addresses 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register select: 0 control, 1 time low, 2 time high, 3 addend, 4 accumulator |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| time_now | output | 64 | Live nanosecond time |
| tick | output | 1 | High in each cycle whose edge advances the time |

## Verification
A wrong accumulator value does not show at the time pins right away. It appears later as a carry that comes one or more cycles early or late, so the bench compares the time and the read-back accumulator after runs of known length against floor(N·addend / 2^32)·period. A fault in the staging or freeze registers shows only on the bus. The bench therefore loads and reads the time while it advances, so that a torn value differs from the expected one in the high half within a few cycles.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned PER_W    = 10;
  localparam int unsigned PER_LSB  = 16;
  localparam int unsigned EN_BIT   = 2;
  localparam int unsigned BYP_BIT  = 3;
  localparam int unsigned SRST_BIT = 5;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL   = 3'd0,
    SEL_TLO    = 3'd1,
    SEL_THI    = 3'd2,
    SEL_ADDEND = 3'd3,
    SEL_ACC    = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/tod_regs.sv
module tod_regs
  import tod_pkg::*;
#(
  parameter int unsigned W     = REG_W,
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned PW    = PER_W,
  parameter int unsigned P_LSB = PER_LSB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  time_lo,
  input  logic [W-1:0]  snap_hi,
  input  logic [W-1:0]  acc_val,
  output logic          ctl_en,
  output logic          ctl_byp,
  output logic          ctl_srst,
  output logic [PW-1:0] ctl_period,
  output logic [W-1:0]  addend,
  output logic          wr_lo,
  output logic          wr_hi,
  output logic          wr_acc,
  output logic          rd_lo,
  output logic [W-1:0]  rdata
);
  localparam logic [W-1:0] PER_MASK  = W'(((1 << PW) - 1) << P_LSB);
  localparam logic [W-1:0] CTRL_MASK = PER_MASK
                                     | (W'(1) << EN_BIT)
                                     | (W'(1) << BYP_BIT)
                                     | (W'(1) << SRST_BIT);

  logic [W-1:0] ctrl_q;
  logic [W-1:0] addend_q;
  logic [W-1:0] rdata_q;
  logic [W-1:0] rd_mux;

  function automatic logic hit(input logic [AW-1:0] a, input reg_sel_e s);
    return a == AW'(s);
  endfunction

  assign wr_lo  = wr_en & hit(addr, SEL_TLO);
  assign wr_hi  = wr_en & hit(addr, SEL_THI);
  assign wr_acc = wr_en & hit(addr, SEL_ACC);
  assign rd_lo  = rd_en & hit(addr, SEL_TLO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      addend_q <= '0;
    end else if (wr_en) begin
      if (hit(addr, SEL_CTRL))   ctrl_q   <= wdata & CTRL_MASK;
      if (hit(addr, SEL_ADDEND)) addend_q <= wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit(addr, SEL_CTRL))   rd_mux = ctrl_q;
    if (hit(addr, SEL_TLO))    rd_mux = time_lo;
    if (hit(addr, SEL_THI))    rd_mux = snap_hi;
    if (hit(addr, SEL_ADDEND)) rd_mux = addend_q;
    if (hit(addr, SEL_ACC))    rd_mux = acc_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign ctl_en     = ctrl_q[EN_BIT];
  assign ctl_byp    = ctrl_q[BYP_BIT];
  assign ctl_srst   = ctrl_q[SRST_BIT];
  assign ctl_period = ctrl_q[P_LSB +: PW];
  assign addend     = addend_q;
  assign rdata      = rdata_q;
endmodule

// File: rtl/tod_accum.sv
module tod_accum
  import tod_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         srst,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] addend,
  output logic [W-1:0] acc,
  output logic         carry
);
  logic [W-1:0] acc_q;
  logic [W:0]   sum;

  function automatic logic [W:0] frac_add(input logic [W-1:0] a, input logic [W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  assign sum   = frac_add(acc_q, addend);
  assign carry = step & ~load & ~srst & sum[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (srst) acc_q <= '0;
    else if (load) acc_q <= load_val;
    else if (step) acc_q <= sum[W-1:0];
  end

  assign acc = acc_q;
endmodule

// File: rtl/tod_time.sv
module tod_time
  import tod_pkg::*;
#(
  parameter int unsigned W  = REG_W,
  parameter int unsigned PW = PER_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           srst,
  input  logic           en,
  input  logic           byp,
  input  logic           carry,
  input  logic [PW-1:0]  period,
  input  logic           wr_lo,
  input  logic           wr_hi,
  input  logic [W-1:0]   wdata,
  input  logic           rd_lo,
  output logic [2*W-1:0] time_q,
  output logic [W-1:0]   snap_hi,
  output logic [W-1:0]   stage_lo,
  output logic           tick,
  output logic           hi_load
);
  localparam int unsigned TW = 2 * W;

  logic [TW-1:0] t_q;
  logic [W-1:0]  stage_q;
  logic [W-1:0]  snap_q;

  function automatic logic [TW-1:0] advance(input logic [TW-1:0] t, input logic [PW-1:0] p);
    return t + TW'(p);
  endfunction

  assign hi_load = wr_hi & ~srst;
  assign tick    = en & ~srst & ~wr_hi & (byp | carry);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q     <= '0;
      stage_q <= '0;
      snap_q  <= '0;
    end else if (srst) begin
      t_q     <= '0;
      stage_q <= '0;
      snap_q  <= '0;
    end else begin
      if (wr_lo)        stage_q <= wdata;
      if (hi_load)      t_q     <= {wdata, stage_q};
      else if (tick)    t_q     <= advance(t_q, period);
      if (rd_lo)        snap_q  <= t_q[TW-1:W];
    end
  end

  assign time_q   = t_q;
  assign snap_hi  = snap_q;
  assign stage_lo = stage_q;
endmodule

// File: rtl/tod_ns_counter.sv
module tod_ns_counter
  import tod_pkg::*;
#(
  parameter int unsigned W  = REG_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned PW = PER_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [AW-1:0]  addr,
  input  logic [W-1:0]   wdata,
  output logic [W-1:0]   rdata,
  output logic [2*W-1:0] time_now,
  output logic           tick
);
  logic          ctl_en, ctl_byp, ctl_srst;
  logic [PW-1:0] ctl_period;
  logic [W-1:0]  addend, acc_q, snap_hi, stage_lo;
  logic          wr_lo, wr_hi, wr_acc, rd_lo;
  logic          carry, hi_load;
  logic [2*W-1:0] time_q;

  tod_regs #(.W(W), .AW(AW), .PW(PW), .P_LSB(PER_LSB)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .time_lo(time_q[W-1:0]), .snap_hi(snap_hi), .acc_val(acc_q),
    .ctl_en(ctl_en), .ctl_byp(ctl_byp), .ctl_srst(ctl_srst),
    .ctl_period(ctl_period), .addend(addend), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_acc(wr_acc), .rd_lo(rd_lo), .rdata(rdata)
  );

  tod_accum #(.W(W)) u_accum (
    .clk(clk), .rst_n(rst_n), .srst(ctl_srst), .step(ctl_en & ~ctl_byp),
    .load(wr_acc), .load_val(wdata), .addend(addend), .acc(acc_q), .carry(carry)
  );

  tod_time #(.W(W), .PW(PW)) u_time (
    .clk(clk), .rst_n(rst_n), .srst(ctl_srst), .en(ctl_en), .byp(ctl_byp),
    .carry(carry), .period(ctl_period), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wdata(wdata), .rd_lo(rd_lo), .time_q(time_q), .snap_hi(snap_hi),
    .stage_lo(stage_lo), .tick(tick), .hi_load(hi_load)
  );

  assign time_now = time_q;
endmodule

// File: rtl/tod_ns_counter_chk.sv
module tod_ns_counter_chk #(
  parameter int unsigned W  = 32,
  parameter int unsigned PW = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2*W-1:0] time_now,
  input logic           tick,
  input logic           en,
  input logic           byp,
  input logic           srst,
  input logic [PW-1:0]  period,
  input logic           hi_load,
  input logic [W-1:0]   stage_lo,
  input logic [W-1:0]   wdata,
  input logic [W-1:0]   acc_val
);
  // R2: an advance strobe moves the time by exactly the period
  a_r2_adv_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (time_now == $past(time_now) + (2*W)'($past(period))));

  // R3: disabled timer holds its time
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !hi_load && !srst) |=> $stable(time_now));

  // R3: no advance strobe while disabled
  a_r3_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tick);

  // R4: bypass advances on every free cycle
  a_r4_bypass_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (en && byp && !srst && !hi_load) |-> tick);

  // R5: soft reset clears time and accumulator
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (time_now == '0 && acc_val == '0));

  // R6: high write loads both halves at once
  a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
    hi_load |=> (time_now == {$past(wdata), $past(stage_lo)}));
endmodule

bind tod_ns_counter tod_ns_counter_chk #(.W(W), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .time_now(time_now), .tick(tick),
  .en(ctl_en), .byp(ctl_byp), .srst(ctl_srst), .period(ctl_period),
  .hi_load(hi_load), .stage_lo(stage_lo), .wdata(wdata), .acc_val(acc_q)
);

// File: tb/sim_tod_ns_counter.sv
`timescale 1ns/1ps
module sim_tod_ns_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] time_now;
  logic        tick;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  localparam logic [31:0] EN   = 32'h4;
  localparam logic [31:0] BYP  = 32'h8;
  localparam logic [31:0] SRST = 32'h20;

  always #2 clk = ~clk;

  tod_ns_counter u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .time_now(time_now), .tick(tick));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] per(input int p);
    return 32'(p) << 16;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic soft_reset(input logic [31:0] ctrl_after);
    reg_wr(3'd0, SRST | ctrl_after);
    reg_wr(3'd0, ctrl_after);
  endtask

  // enables for exactly n advancing edges (n >= 1)
  task automatic run_enabled(input logic [31:0] ctrl, input int n);
    reg_wr(3'd0, ctrl | EN);
    repeat (n - 1) @(negedge clk);
    reg_wr(3'd0, ctrl);
  endtask

  initial begin
    logic [31:0] rv;
    logic [63:0] prod;
    logic [63:0] hold;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 time", time_now, 64'd0);
    chk("R1 tick", {63'd0, tick}, 64'd0);
    reg_rd(3'd0, rv); chk("R1 ctrl", {32'd0, rv}, 64'd0);
    reg_rd(3'd3, rv); chk("R1 addend", {32'd0, rv}, 64'd0);
    reg_rd(3'd4, rv); chk("R1 acc", {32'd0, rv}, 64'd0);

    // R11 control mask, unmapped reads
    reg_wr(3'd0, 32'hFFFF_FFFF);
    reg_rd(3'd0, rv); chk("R11 ctrl mask", {32'd0, rv}, 64'h03FF_002C);
    reg_wr(3'd0, 32'h0);
    for (int a = 5; a < 8; a++) begin
      reg_rd(3'(a), rv); chk("R11 unmapped", {32'd0, rv}, 64'd0);
    end

    // R2 sweep over addends, periods and run lengths
    for (int i = 1; i <= 8; i++) begin
      for (int k = 0; k < 3; k++) begin
        automatic int n = (k == 0) ? 1 : (k == 1) ? 7 : 23;
        automatic logic [31:0] ad = (32'(i) * 32'h1357_9BDF) ^ (32'(i) << 28);
        automatic int p = 1 + i * 97;
        soft_reset(per(p));
        reg_wr(3'd3, ad);
        run_enabled(per(p), n);
        prod = 64'(n) * 64'(ad);
        chk("R2 time", time_now, (prod >> 32) * 64'(p));
        reg_rd(3'd4, rv); chk("R2 acc", {32'd0, rv}, {32'd0, prod[31:0]});
      end
    end

    // R3 disabled holds
    hold = time_now;
    repeat (10) @(negedge clk);
    chk("R3 hold time", time_now, hold);
    chk("R3 no tick", {63'd0, tick}, 64'd0);

    // R8 addend retune keeps fraction
    soft_reset(per(5));
    reg_wr(3'd3, 32'h6000_0000);
    run_enabled(per(5), 9);
    reg_wr(3'd3, 32'h2000_0001);
    run_enabled(per(5), 13);
    prod = 64'd9 * 64'h6000_0000 + 64'd13 * 64'h2000_0001;
    chk("R8 time", time_now, (prod >> 32) * 64'd5);
    reg_rd(3'd4, rv); chk("R8 acc", {32'd0, rv}, {32'd0, prod[31:0]});

    // R5 soft reset clears time/acc, keeps addend
    reg_wr(3'd0, SRST | per(5));
    @(negedge clk);
    chk("R5 time cleared", time_now, 64'd0);
    reg_rd(3'd4, rv); chk("R5 acc cleared", {32'd0, rv}, 64'd0);
    reg_rd(3'd3, rv); chk("R5 addend kept", {32'd0, rv}, 64'h2000_0001);
    reg_wr(3'd0, per(5));

    // R9 accumulator write
    soft_reset(per(7));
    reg_wr(3'd4, 32'hFFFF_FFFF);
    reg_wr(3'd3, 32'h1);
    reg_rd(3'd4, rv); chk("R9 acc readback", {32'd0, rv}, 64'hFFFF_FFFF);
    run_enabled(per(7), 1);
    chk("R9 carry time", time_now, 64'd7);
    reg_rd(3'd4, rv); chk("R9 acc wrapped", {32'd0, rv}, 64'd0);

    // R4 bypass at maximum period
    soft_reset(BYP | per(1023));
    reg_wr(3'd3, 32'h1234);
    run_enabled(BYP | per(1023), 3);
    chk("R4 bypass time", time_now, 64'd3069);
    reg_rd(3'd4, rv); chk("R4 acc holds", {32'd0, rv}, 64'd0);

    // R6 staged low write
    soft_reset(per(3));
    reg_wr(3'd1, 32'h1234_5678);
    chk("R6 low staged only", time_now, 64'd0);
    reg_wr(3'd2, 32'h0000_000A);
    chk("R6 load both", time_now, 64'h0000_000A_1234_5678);

    // R10 wrap, R6 load while running
    soft_reset(BYP | per(4));
    reg_wr(3'd1, 32'hFFFF_FFFE);
    reg_wr(3'd2, 32'hFFFF_FFFF);
    chk("R10 loaded", time_now, 64'hFFFF_FFFF_FFFF_FFFE);
    reg_wr(3'd0, EN | BYP | per(4));
    chk("R10 enable edge", time_now, 64'hFFFF_FFFF_FFFF_FFFE);
    @(negedge clk);
    chk("R10 wrapped", time_now, 64'h2);
    reg_wr(3'd1, 32'h0000_0100);
    reg_wr(3'd2, 32'h0000_0003);
    chk("R6 load wins over advance", time_now, 64'h0000_0003_0000_0100);
    @(negedge clk);
    chk("R6 advance after load", time_now, 64'h0000_0003_0000_0104);
    reg_wr(3'd0, BYP | per(4));

    // R7 coherent split read while running
    soft_reset(BYP | per(16));
    reg_wr(3'd0, EN | BYP | per(16));
    reg_wr(3'd1, 32'hFFFF_FFF0);
    reg_wr(3'd2, 32'h0000_0005);
    reg_rd(3'd1, rv); chk("R7 low", {32'd0, rv}, 64'hFFFF_FFF0);
    repeat (3) @(negedge clk);
    chk("R7 live high moved", {32'd0, time_now[63:32]}, 64'd6);
    reg_rd(3'd2, rv); chk("R7 frozen high", {32'd0, rv}, 64'd5);
    reg_wr(3'd0, BYP | per(16));
    reg_rd(3'd1, rv); chk("R7 low again", {32'd0, rv}, {32'd0, time_now[31:0]});
    reg_rd(3'd2, rv); chk("R7 high again", {32'd0, rv}, {32'd0, time_now[63:32]});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule